// File: doc/BRIEF.md
# Edge-Triggered Interrupt Aggregator

This block gathers ten single-bit request lines coming from the peripherals of an acquisition card and merges them into one interrupt toward the host bridge. A 0-to-1 transition on any line latches a bit in a pending word. When a newly latched source has its enable bit set, the block emits a single-cycle positive pulse on its interrupt output.

Software reaches the block through a small word-wide register port. It holds two registers. The pending word clears itself when read. The enable mask is read and written as a whole word. When a source fires a second time before software has collected its first event, a sticky flag in the top bit of the pending word records the repeat. Reads and incoming edges may fall in the same clock, and no edge is lost when they do.

Top module: `irq_aggregator`

## Requirements
- R1: Each line of `irq_in` is sampled on the rising clock edge. A 0-to-1 change between two consecutive samples sets that line's pending bit. A line held high sets its bit only once. A line that is high in the first sample after reset counts as a rising change.
- R2: Pending bit positions are fixed. Bit 9 is DMA done, bit 8 DMA error, bit 7 carrier over-temperature, bit 6 mezzanine over-temperature, bit 5 input overload, bit 4 ADC trigger, bit 3 shot taken, bit 2 ID-EEPROM serial access done, bit 1 clock-chip serial access done, and bit 0 ADC configuration access done.
- R3: A read (`reg_rd`=1) at address 0 places the pending word on `reg_rdata` in the following cycle and clears all pending bits, including bit 31. In a cycle without a read, `reg_rdata` is 0.
- R4: If a rising change lands in the same cycle as a clearing read, the read returns the old contents and the new edge's bit is set afterwards.
- R5: A newly latched source causes an output pulse only if its enable bit was 1 in the cycle the edge was sampled.
- R6: `irq_pulse` goes high for exactly one cycle, in the cycle after the edge is sampled. Several enabled sources latching in the same cycle give one single pulse.
- R7: Bit 31 of the pending word becomes 1 when a rising change arrives on a source whose pending bit is already set and no clearing read happens in that cycle. It stays set until the next read at address 0.
- R8: The enable mask resets to zero. Address 1 reads the mask in bits [9:0], and a write (`reg_wr`=1) at address 1 loads it from `reg_wdata[9:0]`.
- R9: Bits [30:10] of the pending word and bits [31:10] of the mask read as 0. Reads at addresses 2 and 3 return 0. Writes at addresses other than 1 change nothing.
- R10: After reset, `irq_pulse` is 0, the pending word is 0 and `reg_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 10 | Request lines from peripherals, synchronous to clk |
| reg_rd | input | 1 | Read strobe for one cycle |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 2 | Word address: 0 pending, 1 enable mask |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the strobe |
| irq_pulse | output | 1 | One-cycle interrupt toward the host bridge |

## Verification
Two things can coincide in one clock: a rising change on a source line and a clearing read of the pending word. The bench sets up this collision on purpose. It places edges both on clear bits and on bits that are already pending, and it adds random traffic in which reads and edges overlap often. A cycle-level model derived from the requirements decides the outcome. The read must return the old word, the colliding edge must survive into the next read, and the collision must not raise the repeat flag.

// File: rtl/irqa_pkg.sv
// Shared constants for the interrupt aggregator: source positions and
// register addresses. Assumes a 32-bit register word.
package irqa_pkg;
    localparam int NUM_SRC = 10;
    localparam int DATA_W  = 32;
    localparam int OVF_BIT = 31;
    localparam int ADDR_W  = 2;

    localparam logic [ADDR_W-1:0] ADDR_PEND = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd1;

    // Bit position of each request line in the pending word.
    typedef enum int {
        SRC_ADC_CFG_DONE   = 0,
        SRC_CLKCHIP_DONE   = 1,
        SRC_IDROM_DONE     = 2,
        SRC_SHOT_TAKEN     = 3,
        SRC_ADC_TRIGGER    = 4,
        SRC_INPUT_OVERLOAD = 5,
        SRC_MEZZ_HOT       = 6,
        SRC_CARRIER_HOT    = 7,
        SRC_DMA_ERROR      = 8,
        SRC_DMA_DONE       = 9
    } src_idx_e;
endpackage

// File: rtl/irqa_edge_detect.sv
// Rising-edge detector, one per request line.
// Assumes the lines are already synchronous to clk. The previous sample
// resets to 0, so a line that is high right after reset reports an edge.
module irqa_edge_detect #(
    parameter int N = irqa_pkg::NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] edge_o
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Hold the last sample of line i.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= lvl_i[i];
        end
        // A line is high now and was low at the previous sample.
        assign edge_o[i] = lvl_i[i] & ~prev_q[i];
    end
endmodule

// File: rtl/irqa_src_reg.sv
// Pending-source register with clear-on-read and a sticky repeat flag.
// Assumes clr_i is high for the cycle in which the pending word is read.
// An edge in that same cycle is applied after the clear, so it is kept.
module irqa_src_reg #(
    parameter int N = irqa_pkg::NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] edge_i,
    input  logic         clr_i,
    output logic [N-1:0] pend_o,
    output logic         ovf_o
);
    logic [N-1:0] pend_q;
    logic         ovf_q;
    logic [N-1:0] kept;
    logic         repeat_hit;

    // What survives the read, and whether a set bit fires again.
    always_comb begin
        kept       = clr_i ? '0 : pend_q;
        repeat_hit = |(edge_i & kept);
    end

    // Latch new edges on top of the surviving bits.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= kept | edge_i;
    end

    // Sticky repeat flag, cleared only by a read.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_q <= 1'b0;
        else if (clr_i)   ovf_q <= 1'b0;
        else if (repeat_hit) ovf_q <= 1'b1;
    end

    assign pend_o = pend_q;
    assign ovf_o  = ovf_q;

    // R3
    clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((pend_q & ~$past(edge_i)) == '0) && !ovf_q);

    // R4
    edge_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_i) |=> ((pend_q & $past(edge_i)) == $past(edge_i)));

    // R7
    repeat_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_q) |-> $past(!clr_i && (|(edge_i & pend_q))));
endmodule

// File: rtl/irqa_mask_reg.sv
// Enable mask register, loaded by whole-word writes.
// Assumes wr_i is already qualified by the mask address.
module irqa_mask_reg #(
    parameter int N = irqa_pkg::NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] mask_o
);
    logic [N-1:0] mask_q;

    // Load the mask on a write and clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    mask_q <= '0;
        else if (wr_i) mask_q <= wdata_i;
    end

    assign mask_o = mask_q;

    // R8
    mask_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (mask_q == '0));
endmodule

// File: rtl/irq_aggregator.sv
// Interrupt aggregator top. It detects edges, latches pending sources,
// gates them with the enable mask into one pulse, and serves a
// two-register read/write port whose read data is registered.
// Assumes one access per strobe and full-word accesses only.
module irq_aggregator #(
    parameter int NUM_SRC = irqa_pkg::NUM_SRC,
    parameter int DATA_W  = irqa_pkg::DATA_W,
    parameter int OVF_BIT = irqa_pkg::OVF_BIT,
    parameter int ADDR_W  = irqa_pkg::ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               reg_rd,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq_pulse
);
    import irqa_pkg::*;

    logic [NUM_SRC-1:0] edges;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] mask;
    logic               ovf;
    logic               rd_pend;
    logic               wr_mask;
    logic [DATA_W-1:0]  rd_word;
    logic [DATA_W-1:0]  rdata_q;
    logic               pulse_q;
    logic               unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_SRC];

    // Decode the strobes by address.
    always_comb begin
        rd_pend = reg_rd && (reg_addr == ADDR_W'(ADDR_PEND));
        wr_mask = reg_wr && (reg_addr == ADDR_W'(ADDR_MASK));
    end

    irqa_edge_detect #(.N(NUM_SRC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (irq_in),
        .edge_o (edges)
    );

    irqa_src_reg #(.N(NUM_SRC)) u_src (
        .clk    (clk),
        .rst_n  (rst_n),
        .edge_i (edges),
        .clr_i  (rd_pend),
        .pend_o (pend),
        .ovf_o  (ovf)
    );

    irqa_mask_reg #(.N(NUM_SRC)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_mask),
        .wdata_i (reg_wdata[NUM_SRC-1:0]),
        .mask_o  (mask)
    );

    // Select the word to return; unmapped bits and addresses give 0.
    always_comb begin
        rd_word = '0;
        if (reg_rd) begin
            if (reg_addr == ADDR_W'(ADDR_PEND)) begin
                rd_word[NUM_SRC-1:0] = pend;
                rd_word[OVF_BIT]     = ovf;
            end else if (reg_addr == ADDR_W'(ADDR_MASK)) begin
                rd_word[NUM_SRC-1:0] = mask;
            end
        end
    end

    // Register the read data for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rd_word;
    end

    // Any enabled new edge gives one pulse in the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= |(edges & mask);
    end

    assign reg_rdata = rdata_q;
    assign irq_pulse = pulse_q;

    // R6
    pulse_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> |(pend & $past(mask)));

    // R9
    unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_q[OVF_BIT-1:NUM_SRC] == '0);
endmodule

// File: tb/irq_aggregator_tb.sv
// Bench: directed sweeps plus random traffic, checked against a
// cycle-level model that follows the requirements.
module irq_aggregator_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 10;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] irq = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pulse;

    int vectors = 0;
    int fails = 0;

    // model state
    logic [N-1:0] m_prev = '0, m_pend = '0, m_en = '0;
    logic         m_ovf = 1'b0, e_pulse = 1'b0;
    logic [31:0]  e_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_aggregator u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq), .reg_rd(rd), .reg_wr(wr),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_pulse(pulse)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Advance one clock: predict, let the edge pass, compare at negedge.
    task automatic cyc(input string tag);
        logic [N-1:0] edg;
        logic         clr;
        edg = irq & ~m_prev;
        clr = rd && addr == 2'd0;
        if (!rst_n) begin
            m_prev = '0; m_pend = '0; m_en = '0; m_ovf = 0;
            e_pulse = 0; e_rdata = '0;
        end else begin
            e_rdata = '0;
            if (rd && addr == 2'd0) e_rdata = {m_ovf, 21'd0, m_pend};
            if (rd && addr == 2'd1) e_rdata = {22'd0, m_en};
            e_pulse = |(edg & m_en);
            m_ovf = clr ? 1'b0 : (m_ovf | (|(edg & m_pend)));
            m_pend = (clr ? '0 : m_pend) | edg;
            if (wr && addr == 2'd1) m_en = wdata[N-1:0];
            m_prev = irq;
        end
        @(posedge clk);
        @(negedge clk);
        check({tag, " pulse"}, {31'd0, pulse}, {31'd0, e_pulse});
        check({tag, " rdata"}, rdata, e_rdata);
    endtask

    task automatic read_reg(input string tag, input logic [1:0] a);
        rd = 1; addr = a; cyc(tag); rd = 0; addr = '0;
    endtask

    task automatic write_mask(input string tag, input logic [31:0] d);
        wr = 1; addr = 2'd1; wdata = d; cyc(tag); wr = 0; addr = '0; wdata = '0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R10 reset state
        cyc("R10 reset"); cyc("R10 reset");
        rst_n = 1;
        cyc("R10 idle");
        check("R10 pulse after reset", {31'd0, pulse}, 32'd0);
        read_reg("R10 pending", 2'd0);
        check("R10 pending zero", rdata, 32'd0);
        read_reg("R8 mask reset", 2'd1);
        check("R8 mask zero", rdata, 32'd0);

        // R2 bit positions, one line at a time
        for (int s = 0; s < N; s++) begin
            irq = N'(1) << s; cyc("R2 edge"); irq = '0; cyc("R2 low");
            read_reg("R2 read", 2'd0);
            check("R2 position", rdata, 32'd1 << s);
        end
        // R2 named lines: DMA done at 9, ADC configuration done at 0
        irq = 10'h201; cyc("R2 named"); irq = '0;
        read_reg("R2 named read", 2'd0);
        check("R2 dma-done and cfg-done", rdata, 32'h0000_0201);

        // R1 a held line latches once
        irq = 10'h010; cyc("R1 rise");
        read_reg("R1 first read", 2'd0);
        check("R1 first read", rdata, 32'h10);
        cyc("R1 held"); cyc("R1 held");
        read_reg("R1 second read", 2'd0);
        check("R1 held gives no new bit", rdata, 32'h0);
        irq = '0; cyc("R1 fall");

        // R8 mask write/read, R9 upper bits ignored
        write_mask("R8 write", 32'hFFFF_FC00 | 32'h2A5);
        read_reg("R8 read", 2'd1);
        check("R8 R9 mask readback", rdata, 32'h2A5);

        // R9 writes to other addresses and reads of unmapped addresses
        irq = 10'h004; cyc("R9 set"); irq = '0;
        wr = 1; addr = 2'd0; wdata = '1; cyc("R9 write pend"); wr = 0;
        addr = 2'd2; wr = 1; cyc("R9 write a2"); wr = 0; wdata = '0;
        read_reg("R9 addr2", 2'd2);
        check("R9 addr2 zero", rdata, 32'd0);
        read_reg("R9 addr3", 2'd3);
        check("R9 addr3 zero", rdata, 32'd0);
        read_reg("R9 mask kept", 2'd1);
        check("R9 mask unchanged", rdata, 32'h2A5);
        read_reg("R9 pending kept", 2'd0);
        check("R9 pending unchanged", rdata, 32'h4);

        // R5 sweep of all masks against every line
        for (int m = 0; m < (1 << N); m++) begin
            write_mask("R5 mask", 32'(m));
            for (int s = 0; s < N; s++) begin
                irq = N'(1) << s; cyc("R5 edge"); irq = '0;
                cyc("R5 pulse");
            end
            read_reg("R5 drain", 2'd0);
        end

        // R6 many lines at once: one pulse, one cycle
        write_mask("R6 mask", 32'h3FF);
        irq = 10'h3FF; cyc("R6 burst");
        check("R6 pulse high", {31'd0, pulse}, 32'd1);
        cyc("R6 held");
        check("R6 pulse one cycle", {31'd0, pulse}, 32'd0);
        irq = '0; cyc("R6 low");
        read_reg("R6 drain", 2'd0);

        // R7 repeat flag
        irq = 10'h008; cyc("R7 first"); irq = '0; cyc("R7 low");
        irq = 10'h008; cyc("R7 again"); irq = '0;
        read_reg("R7 read", 2'd0);
        check("R7 flag set", rdata, 32'h8000_0008);
        read_reg("R7 reread", 2'd0);
        check("R7 flag cleared", rdata, 32'h0);

        // R4 edge in the read cycle, on a clear bit and on a set bit
        irq = 10'h020; cyc("R4 prime"); irq = '0; cyc("R4 low");
        irq = 10'h022; rd = 1; addr = 2'd0; cyc("R4 collide"); rd = 0; irq = '0;
        check("R4 read returns old", rdata, 32'h20);
        read_reg("R4 after", 2'd0);
        check("R4 edge kept, no repeat flag", rdata, 32'h22);

        // R3 R4 R7 random traffic
        for (int i = 0; i < 40000; i++) begin
            irq   = N'($urandom & $urandom);
            rd    = ($urandom % 3) == 0;
            wr    = ($urandom % 16) == 0;
            addr  = 2'($urandom);
            wdata = $urandom;
            cyc("R3 R4 R7 random");
        end
        irq = '0; rd = 0; wr = 0;
        cyc("R3 tail");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule